// File: doc/BRIEF.md
# Front-Panel Bus Access Sequencer

This controller connects a maintenance front panel to a shared system bus. When the operator presses the address-read key or the address-write key, it runs a short step sequence. First it requests the bus. Once the bus is granted, it drives the address set on the address switches. What happens on the data lines depends on the operation:

- **Write:** the controller drives the value set on the data switches, so that value is stored at the chosen address.
- **Read:** the controller drives zero on the data lines. The addressed slave returns a word, and the controller captures it for the data display.

The sequence ends when the slave acknowledges or signals quit. At that point a done indicator lights and stays lit.

Read and write use one shared sequence. The only difference between them is which operation-select line is raised. The key inputs are debounced single-cycle pulses. Key presses that arrive while a sequence is running are ignored. The switch values are captured when a sequence is accepted, so moving the switches mid-sequence has no effect on the bus.

Top module: `fpbus_seq`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge: `bus_req`, `rd_sel`, `wr_sel`, `addr_oe`, `data_oe`, `bus_addr`, `bus_dout`, `disp_data` and `done`.
- R2: A `rd_go` or `wr_go` pulse sampled while the sequencer is idle has these effects one cycle later:
  - `bus_req` is 1.
  - `rd_sel` is 1 for a read or `wr_sel` is 1 for a write, and the other select is 0.
  - `done` is 0.
- R3: `bus_req` stays 1 until `bus_gnt` is sampled high. One cycle after that sample:
  - `bus_req` is 0 and `addr_oe` is 1.
  - `bus_addr` equals the `addr_sw` value captured with the start pulse.
  - Before that point, `addr_oe` is 0 and `bus_addr` is 0.
- R4: For a write, `data_oe` rises in the same cycle as `addr_oe`, and `bus_dout` equals the `data_sw` value captured with the start pulse.
- R5: For a read, `data_oe` stays 0 and `bus_dout` stays 0 for the whole sequence.
- R6: The drive enables and the address and data values are held until `slv_ack` or `slv_quit` is sampled high. One cycle after that sample:
  - `addr_oe`, `data_oe`, `rd_sel`, `wr_sel`, `bus_addr` and `bus_dout` are all 0.
  - `done` is 1.
- R7: A read that ends with `slv_ack` high loads `disp_data` with the `bus_din` value sampled in that same cycle. A read that ends on `slv_quit` alone leaves `disp_data` unchanged, and so does any write.
- R8: `done` stays 1 until `rst` or the next accepted start pulse.
- R9: A `rd_go` or `wr_go` pulse sampled while a sequence is running is ignored. It does not change the selects, the request, the drive enables, or the driven address and data.
- R10: If `rd_go` and `wr_go` are sampled high together while idle, the sequencer performs a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, synchronous, active high |
| rd_go | input | 1 | Address-read key pulse |
| wr_go | input | 1 | Address-write key pulse |
| addr_sw | input | 16 | Address switch register |
| data_sw | input | 16 | Data switch register |
| bus_gnt | input | 1 | Bus access granted |
| slv_ack | input | 1 | Slave done acknowledge |
| slv_quit | input | 1 | Slave quit acknowledge |
| bus_din | input | 16 | Data returned by the slave |
| bus_req | output | 1 | Bus access request |
| rd_sel | output | 1 | Read operation select |
| wr_sel | output | 1 | Write operation select |
| addr_oe | output | 1 | Address drive enable |
| data_oe | output | 1 | Data drive enable |
| bus_addr | output | 16 | Address driven onto the bus |
| bus_dout | output | 16 | Data driven onto the bus |
| disp_data | output | 16 | Captured value for the data display |
| done | output | 1 | Done indicator |

## Verification
A sequencer stuck in the wrong step shows within one cycle of the next handshake edge. Either `bus_req` fails to drop on grant, or `addr_oe` fails to rise or fall, and the bench checks these on every transaction. A wrong operation latch shows when the drive enables rise: a read would present `data_oe` or nonzero `bus_dout`, or a write would present zero data. A bad capture register shows in `disp_data` one cycle after the acknowledge. Random switch changes and busy key pulses during a sequence expose any path that reloads state outside the idle step.

// File: rtl/fpbus_pkg.sv
package fpbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DRV  = 2'd2
  } seq_st_t;
endpackage

// File: rtl/fpbus_ctl.sv
module fpbus_ctl
  import fpbus_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rd_go,
  input  logic wr_go,
  input  logic bus_gnt,
  input  logic slv_ack,
  input  logic slv_quit,
  output logic start_acc,
  output logic grant_acc,
  output logic finish,
  output logic op_wr,
  output logic bus_req,
  output logic rd_sel,
  output logic wr_sel,
  output logic addr_oe,
  output logic data_oe
);
  seq_st_t st;

  // start is only taken in idle; read wins a tie
  assign start_acc = (st == ST_IDLE) && (rd_go || wr_go);
  assign grant_acc = (st == ST_REQ) && bus_gnt;
  assign finish    = (st == ST_DRV) && (slv_ack || slv_quit);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      op_wr   <= 1'b0;
      bus_req <= 1'b0;
      rd_sel  <= 1'b0;
      wr_sel  <= 1'b0;
      addr_oe <= 1'b0;
      data_oe <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start_acc) begin
          st      <= ST_REQ;
          op_wr   <= ~rd_go;
          bus_req <= 1'b1;
          rd_sel  <= rd_go;
          wr_sel  <= ~rd_go;
        end
        ST_REQ: if (grant_acc) begin
          st      <= ST_DRV;
          bus_req <= 1'b0;
          addr_oe <= 1'b1;
          data_oe <= op_wr;
        end
        ST_DRV: if (finish) begin
          st      <= ST_IDLE;
          rd_sel  <= 1'b0;
          wr_sel  <= 1'b0;
          addr_oe <= 1'b0;
          data_oe <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_gnt |=> bus_req); // R3
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_gnt |=> !bus_req && addr_oe); // R3
  AST_SEL_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(rd_sel && wr_sel)); // R2
  AST_DRV_HOLD: assert property (@(posedge clk) disable iff (rst)
    addr_oe && !slv_ack && !slv_quit |=> addr_oe); // R6
endmodule

// File: rtl/fpbus_dpath.sv
module fpbus_dpath #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_acc,
  input  logic          grant_acc,
  input  logic          finish,
  input  logic          op_wr,
  input  logic          slv_ack,
  input  logic [AW-1:0] addr_sw,
  input  logic [DW-1:0] data_sw,
  input  logic [DW-1:0] bus_din,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic [DW-1:0] disp_data
);
  localparam logic [DW-1:0] DZERO = '0;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q    <= '0;
      data_q    <= '0;
      bus_addr  <= '0;
      bus_dout  <= '0;
      disp_data <= '0;
    end else begin
      if (start_acc) begin
        addr_q <= addr_sw;
        data_q <= data_sw;
      end
      if (grant_acc) begin
        bus_addr <= addr_q;
        bus_dout <= op_wr ? data_q : DZERO;
      end else if (finish) begin
        bus_addr <= '0;
        bus_dout <= '0;
      end
      if (finish && !op_wr && slv_ack)
        disp_data <= bus_din;
    end
  end

  AST_DISP_KEEP: assert property (@(posedge clk) disable iff (rst)
    !finish |=> $stable(disp_data)); // R7
endmodule

// File: rtl/fpbus_done.sv
module fpbus_done (
  input  logic clk,
  input  logic rst,
  input  logic start_acc,
  input  logic finish,
  output logic done
);
  always_ff @(posedge clk) begin
    if (rst)            done <= 1'b0;
    else if (start_acc) done <= 1'b0;
    else if (finish)    done <= 1'b1;
  end

  AST_DONE_SET: assert property (@(posedge clk) disable iff (rst)
    finish |=> done); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    done && !start_acc |=> done); // R8
endmodule

// File: rtl/fpbus_seq.sv
module fpbus_seq #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_go,
  input  logic          wr_go,
  input  logic [AW-1:0] addr_sw,
  input  logic [DW-1:0] data_sw,
  input  logic          bus_gnt,
  input  logic          slv_ack,
  input  logic          slv_quit,
  input  logic [DW-1:0] bus_din,
  output logic          bus_req,
  output logic          rd_sel,
  output logic          wr_sel,
  output logic          addr_oe,
  output logic          data_oe,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic [DW-1:0] disp_data,
  output logic          done
);
  logic start_acc, grant_acc, finish, op_wr;

  fpbus_ctl u_ctl (
    .clk(clk), .rst(rst), .rd_go(rd_go), .wr_go(wr_go),
    .bus_gnt(bus_gnt), .slv_ack(slv_ack), .slv_quit(slv_quit),
    .start_acc(start_acc), .grant_acc(grant_acc), .finish(finish),
    .op_wr(op_wr), .bus_req(bus_req), .rd_sel(rd_sel), .wr_sel(wr_sel),
    .addr_oe(addr_oe), .data_oe(data_oe)
  );

  fpbus_dpath #(.AW(AW), .DW(DW)) u_dpath (
    .clk(clk), .rst(rst), .start_acc(start_acc), .grant_acc(grant_acc),
    .finish(finish), .op_wr(op_wr), .slv_ack(slv_ack),
    .addr_sw(addr_sw), .data_sw(data_sw), .bus_din(bus_din),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .disp_data(disp_data)
  );

  fpbus_done u_done (
    .clk(clk), .rst(rst), .start_acc(start_acc), .finish(finish),
    .done(done)
  );

  AST_RD_NODATA: assert property (@(posedge clk) disable iff (rst)
    rd_sel |-> !data_oe && (bus_dout == '0)); // R5
  AST_WR_DATA: assert property (@(posedge clk) disable iff (rst)
    addr_oe && wr_sel |-> data_oe); // R4
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    addr_oe && $past(addr_oe) |-> $stable(bus_addr)); // R9
  AST_NO_ADDR_EARLY: assert property (@(posedge clk) disable iff (rst)
    !addr_oe |-> bus_addr == '0); // R3
endmodule

// File: tb/fpbus_seq_bench.sv
module fpbus_seq_bench;
  logic clk = 1'b0;
  logic rst;
  logic rd_go, wr_go, bus_gnt, slv_ack, slv_quit;
  logic [15:0] addr_sw, data_sw, bus_din;
  logic bus_req, rd_sel, wr_sel, addr_oe, data_oe, done;
  logic [15:0] bus_addr, bus_dout, disp_data;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] exp_disp;

  always #5 clk = ~clk;

  fpbus_seq u_fpbus_seq (
    .clk(clk), .rst(rst), .rd_go(rd_go), .wr_go(wr_go),
    .addr_sw(addr_sw), .data_sw(data_sw), .bus_gnt(bus_gnt),
    .slv_ack(slv_ack), .slv_quit(slv_quit), .bus_din(bus_din),
    .bus_req(bus_req), .rd_sel(rd_sel), .wr_sel(wr_sel),
    .addr_oe(addr_oe), .data_oe(data_oe), .bus_addr(bus_addr),
    .bus_dout(bus_dout), .disp_data(disp_data), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_dout(input bit wr, input logic [15:0] d);
    return wr ? d : 16'h0000;
  endfunction

  // one full transaction; rdwr: 0 read,1 write,2 both pulses (read)
  task automatic run_op(input int kind, input int gdly, input int adly,
                        input bit use_quit, input bit also_ack, input bit noise);
    logic [15:0] a = 16'($urandom);
    logic [15:0] d = 16'($urandom);
    logic [15:0] rv = 16'($urandom);
    bit wr = (kind == 1);
    @(negedge clk);
    addr_sw = a; data_sw = d;
    rd_go = (kind != 1); wr_go = (kind != 0);
    @(negedge clk);
    rd_go = 0; wr_go = 0;
    addr_sw = 16'($urandom); data_sw = 16'($urandom);
    chk("R2 bus_req", {31'b0, bus_req}, 1);
    chk(kind == 2 ? "R10 rd_sel" : "R2 rd_sel", {31'b0, rd_sel}, {31'b0, !wr});
    chk("R2 wr_sel", {31'b0, wr_sel}, {31'b0, wr});
    chk("R2 done", {31'b0, done}, 0);
    for (int i = 0; i < gdly; i++) begin
      if (noise) begin rd_go = i[0]; wr_go = !i[0]; end
      @(negedge clk);
      rd_go = 0; wr_go = 0;
      chk("R3 req held", {31'b0, bus_req}, 1);
      chk("R3 no addr early", {15'b0, addr_oe, bus_addr}, 0);
      chk("R9 sel kept", {30'b0, rd_sel, wr_sel}, {30'b0, !wr, wr});
    end
    bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0;
    chk("R3 req drop", {31'b0, bus_req}, 0);
    chk("R3 addr_oe", {31'b0, addr_oe}, 1);
    chk("R3 bus_addr", {16'b0, bus_addr}, {16'b0, a});
    chk(wr ? "R4 data_oe" : "R5 data_oe", {31'b0, data_oe}, {31'b0, wr});
    chk(wr ? "R4 bus_dout" : "R5 bus_dout", {16'b0, bus_dout}, {16'b0, exp_dout(wr, d)});
    for (int i = 0; i < adly; i++) begin
      if (noise) begin rd_go = 1; wr_go = i[0]; end
      bus_din = 16'($urandom);
      @(negedge clk);
      rd_go = 0; wr_go = 0;
      chk("R6 hold oe", {30'b0, addr_oe, data_oe}, {30'b0, 1'b1, wr});
      chk("R9 addr kept", {16'b0, bus_addr}, {16'b0, a});
      chk("R9 dout kept", {16'b0, bus_dout}, {16'b0, exp_dout(wr, d)});
      chk("R9 no req", {31'b0, bus_req}, 0);
    end
    bus_din = rv;
    slv_ack = !use_quit || also_ack;
    slv_quit = use_quit;
    if (!wr && slv_ack) exp_disp = rv;
    @(negedge clk);
    slv_ack = 0; slv_quit = 0; bus_din = 16'($urandom);
    chk("R6 oe off", {26'b0, addr_oe, data_oe, rd_sel, wr_sel, bus_req, 1'b0}, 0);
    chk("R6 bus idle", {bus_addr, bus_dout}, 0);
    chk("R6 done", {31'b0, done}, 1);
    chk("R7 disp", {16'b0, disp_data}, {16'b0, exp_disp});
    for (int i = 0; i < 2; i++) begin
      bus_gnt = 1'($urandom);
      @(negedge clk);
      bus_gnt = 0;
      chk("R8 done held", {31'b0, done}, 1);
      chk("R8 idle quiet", {31'b0, bus_req | addr_oe}, 0);
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1; rd_go = 0; wr_go = 0; bus_gnt = 0; slv_ack = 0; slv_quit = 0;
    addr_sw = 16'hFFFF; data_sw = 16'hFFFF; bus_din = 16'hFFFF;
    exp_disp = 16'h0000;
    repeat (3) @(negedge clk);
    chk("R1 reset outs", {26'b0, bus_req, rd_sel, wr_sel, addr_oe, data_oe, done}, 0);
    chk("R1 reset buses", {bus_addr, bus_dout}, 0);
    chk("R1 reset disp", {16'b0, disp_data}, 0);
    rst = 0;
    // directed
    run_op(0, 0, 0, 0, 0, 0);  // read, immediate grant/ack
    run_op(1, 2, 3, 0, 0, 1);  // write with noise pulses
    run_op(0, 1, 1, 1, 0, 0);  // read ends on quit: no capture
    run_op(2, 1, 0, 1, 1, 0);  // both pulses -> read, ack+quit captures
    // random
    for (int k = 0; k < 60; k++)
      run_op(int'($urandom_range(0, 2)), int'($urandom_range(0, 5)),
             int'($urandom_range(0, 5)), 1'($urandom), 1'($urandom), 1'($urandom));
    // reset clears done and display mid-idle
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    chk("R1 reset done", {31'b0, done}, 0);
    chk("R1 reset disp2", {16'b0, disp_data}, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule